// File: doc/BRIEF.md
# Halt-and-Poke Single-Byte Memory Writer

This block stores one nibble into system static RAM while the processor is parked. A clean, already-debounced request input starts a sequence. The block first pulls an active-low halt line to the processor, then waits for the processor to finish its instruction, float its buses and raise bus-available. Only after that does it drive the in-bank address, the data nibble and the target bank's active-low chip enable. It gives one active-low write strobe of programmable width. It then stops driving and frees the processor.

The target is word 0 or word 1 of the upper RAM bank (system address 0x100 or 0x101), picked by one switch. The stored nibble is 0x0 or 0x1, picked by another switch. The request, the switches and all strobes are plain level signals. Each rising edge of the request produces at most one write. If bus-available never arrives, a timeout abandons the attempt and raises a sticky error flag.

Top module: `sram_poke_dma`

## Requirements
- R1: After reset, and while idle, halt_n=1, bus_oe=0, we_n=1, every ce_n bit is 1 and err_timeout=0.
- R2: A rising edge on req drives halt_n low. bus_oe is 1 only while bus_avail is 1 and halt_n is 0.
- R3: halt_n is low for at least one full cycle before bus_oe rises.
- R4: While bus_oe=1, addr_o equals {zeros, sw_addr_lsb} (in-bank word 0 or 1). ce_n bit TGT_BANK (bit 1 by default, the upper bank) is 0 and every other ce_n bit is 1.
- R5: While bus_oe=1, data_o equals {3'b000, sw_data_lsb}.
- R6: we_n is low for exactly max(wr_cycles,1) consecutive cycles. Before the strobe, one cycle has address, data and chip enable driven with we_n=1. After it, one more such cycle follows. bus_oe is therefore high for max(wr_cycles,1)+2 cycles.
- R7: Each rising edge of req gives at most one write. Holding req high causes no further halt or write. req must go low and then high again before another write.
- R8: No memory location other than the selected target word of the target bank is written.
- R9: If bus_avail stays low for TIMEOUT cycles after halt, halt_n returns high, err_timeout becomes 1, and nothing is driven. err_timeout clears when the next request is accepted.
- R10: After the hold cycle, halt_n returns to 1 and bus_oe to 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Debounced write request, level |
| sw_addr_lsb | input | 1 | Selects target word 0 or 1 |
| sw_data_lsb | input | 1 | Low bit of the nibble to store |
| wr_cycles | input | WR_W | Write strobe width in cycles (0 acts as 1) |
| bus_avail | input | 1 | Processor bus-available acknowledge |
| halt_n | output | 1 | Active-low halt request to the processor |
| bus_oe | output | 1 | Drive enable for addr_o, data_o, ce_n, we_n |
| addr_o | output | ADDR_W | In-bank address |
| data_o | output | DATA_W | Data nibble |
| ce_n | output | NUM_BANKS | Active-low bank chip enables |
| we_n | output | 1 | Active-low write strobe |
| err_timeout | output | 1 | Sticky bus-available timeout flag |

## Verification
A table of requests varies the two switches, the strobe width (0, 1, 3 and the maximum) and the processor's bus-available delay. This separates correct address and data routing from swapped or constant bits, and shows whether the strobe width and setup/hold framing hold at every width. A model RAM of both banks is compared after every request to catch writes to other locations. Directed cases hold bus-available low to exercise the timeout. They also keep req high after both a timeout and a finished write to show that no second halt occurs, and they check that the error flag clears on the next accepted request.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HALTREQ = 3'd1,
    ST_WAITBA  = 3'd2,
    ST_SETUP   = 3'd3,
    ST_WRITE   = 3'd4,
    ST_HOLD    = 3'd5,
    ST_RELEASE = 3'd6
  } seq_state_t;
endpackage

// File: rtl/dma_timer.sv
module dma_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int WR_W    = 4,
  parameter int TIMEOUT = 64,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             bus_avail,
  input  logic [WR_W-1:0]  wr_cycles,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             halt_n,
  output logic             drive,
  output logic             we_phase,
  output logic             err_timeout
);
  seq_state_t st, st_nx;
  logic req_q;
  logic start;

  assign start = req && !req_q;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:    if (start) st_nx = ST_HALTREQ;
      ST_HALTREQ: st_nx = ST_WAITBA;
      ST_WAITBA:  if (bus_avail) st_nx = ST_SETUP;
                  else if (tmr_zero) st_nx = ST_IDLE;
      ST_SETUP:   st_nx = ST_WRITE;
      ST_WRITE:   if (tmr_zero) st_nx = ST_HOLD;
      ST_HOLD:    st_nx = ST_RELEASE;
      ST_RELEASE: if (!req) st_nx = ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      req_q       <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      st    <= st_nx;
      req_q <= req;
      if (st == ST_IDLE && start)
        err_timeout <= 1'b0;
      else if (st == ST_WAITBA && !bus_avail && tmr_zero)
        err_timeout <= 1'b1;
    end
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (st == ST_HALTREQ) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(TIMEOUT);
    end else if (st == ST_SETUP) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(wr_cycles);
    end
  end

  assign halt_n   = (st == ST_IDLE) || (st == ST_RELEASE);
  assign drive    = (st == ST_SETUP) || (st == ST_WRITE) || (st == ST_HOLD);
  assign we_phase = (st == ST_WRITE);

  // R9
  timeout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> halt_n && !drive);
  // R7
  release_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RELEASE && req) |=> st == ST_RELEASE);
endmodule

// File: rtl/dma_bus_drive.sv
module dma_bus_drive #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 4,
  parameter int NUM_BANKS = 2,
  parameter int TGT_BANK  = 1
) (
  input  logic                 drive,
  input  logic                 we_phase,
  input  logic                 bus_avail,
  input  logic                 sw_addr_lsb,
  input  logic                 sw_data_lsb,
  output logic                 bus_oe,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [DATA_W-1:0]    data_o,
  output logic [NUM_BANKS-1:0] ce_n,
  output logic                 we_n
);
  assign bus_oe = drive && bus_avail;
  assign addr_o = bus_oe ? {{(ADDR_W-1){1'b0}}, sw_addr_lsb} : '0;
  assign data_o = bus_oe ? {{(DATA_W-1){1'b0}}, sw_data_lsb} : '0;
  assign we_n   = !(bus_oe && we_phase);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    if (b == TGT_BANK) begin : g_tgt
      assign ce_n[b] = !bus_oe;
    end else begin : g_other
      assign ce_n[b] = 1'b1;
    end
  end
endmodule

// File: rtl/sram_poke_dma.sv
module sram_poke_dma #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 4,
  parameter int NUM_BANKS = 2,
  parameter int TGT_BANK  = 1,
  parameter int WR_W      = 4,
  parameter int TIMEOUT   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 sw_addr_lsb,
  input  logic                 sw_data_lsb,
  input  logic [WR_W-1:0]      wr_cycles,
  input  logic                 bus_avail,
  output logic                 halt_n,
  output logic                 bus_oe,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [DATA_W-1:0]    data_o,
  output logic [NUM_BANKS-1:0] ce_n,
  output logic                 we_n,
  output logic                 err_timeout
);
  localparam int TMO_W = $clog2(TIMEOUT + 1);
  localparam int CNT_W = (TMO_W > WR_W) ? TMO_W : WR_W;

  logic             tmr_load, tmr_zero, drive, we_phase;
  logic [CNT_W-1:0] tmr_val;

  dma_seq #(.WR_W(WR_W), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_avail(bus_avail),
    .wr_cycles(wr_cycles), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .halt_n(halt_n), .drive(drive),
    .we_phase(we_phase), .err_timeout(err_timeout)
  );

  dma_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  dma_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS),
                  .TGT_BANK(TGT_BANK)) u_drv (
    .drive(drive), .we_phase(we_phase), .bus_avail(bus_avail),
    .sw_addr_lsb(sw_addr_lsb), .sw_data_lsb(sw_data_lsb),
    .bus_oe(bus_oe), .addr_o(addr_o), .data_o(data_o), .ce_n(ce_n),
    .we_n(we_n)
  );

  // R2
  drive_under_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !halt_n && bus_avail);
  // R3
  halt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(!halt_n));
  // R6
  strobe_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> bus_oe && !ce_n[TGT_BANK]);
  // R4
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);
  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_oe) && $past(we_n)) |-> halt_n);
endmodule

// File: tb/sram_poke_dma_bench.sv
module sram_poke_dma_bench;
  localparam int WR_W = 4;
  localparam int TMO  = 64;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic sw_a = 1'b0, sw_d = 1'b0, ba = 1'b0;
  logic [WR_W-1:0] wc = '0;
  logic halt_n, bus_oe, we_n, err;
  logic [7:0] addr_o;
  logic [3:0] data_o;
  logic [1:0] ce_n;

  always #4 clk = ~clk;

  sram_poke_dma #(.WR_W(WR_W), .TIMEOUT(TMO)) u_sram_poke_dma (
    .clk(clk), .rst_n(rst_n), .req(req), .sw_addr_lsb(sw_a),
    .sw_data_lsb(sw_d), .wr_cycles(wc), .bus_avail(ba), .halt_n(halt_n),
    .bus_oe(bus_oe), .addr_o(addr_o), .data_o(data_o), .ce_n(ce_n),
    .we_n(we_n), .err_timeout(err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // processor model and RAM model, updated away from the active edge
  bit ba_en = 1; int ba_dly = 0; int hcnt = 0;
  logic [3:0] ram [2][256];
  logic [3:0] mirror [2][256];
  int we_lo, oe_cyc, writes, bad_oe, halt_lo_seen;
  int cap_addr, cap_data, cap_ce;
  logic we_q = 1'b1;

  always @(negedge clk) begin
    if (!halt_n) begin
      halt_lo_seen <= 1;
      if (ba_en && hcnt >= ba_dly) ba <= 1'b1;
      else hcnt <= hcnt + 1;
    end else begin
      ba <= 1'b0; hcnt <= 0;
    end
    if (bus_oe) begin
      oe_cyc <= oe_cyc + 1;
      if (halt_lo_seen == 0 || !ba) bad_oe <= bad_oe + 1;
    end
    if (!we_n) begin
      we_lo <= we_lo + 1;
      cap_addr <= addr_o; cap_data <= data_o; cap_ce <= ce_n;
      for (int b = 0; b < 2; b++)
        if (!ce_n[b]) ram[b][addr_o] <= data_o;
    end
    if (we_q && !we_n) writes <= writes + 1;
    we_q <= we_n;
  end

  task automatic clr_mon();
    @(posedge clk);
    we_lo = 0; oe_cyc = 0; writes = 0; bad_oe = 0; halt_lo_seen = 0;
  endtask

  task automatic ram_cmp(input string tag);
    int bad = 0;
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 256; a++)
        if (ram[b][a] !== mirror[b][a]) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic run_op(input bit a, input bit d, input int w, input int dl);
    int exp_w = (w == 0) ? 1 : w;
    @(negedge clk);
    sw_a = a; sw_d = d; wc = WR_W'(w); ba_dly = dl; ba_en = 1;
    clr_mon();
    @(negedge clk); req = 1'b1;
    for (int i = 0; i < 200 && halt_n; i++) @(negedge clk);
    for (int i = 0; i < 200 && !halt_n; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    mirror[1][a] = {3'b000, d};
    check(writes == 1, "R7 one write", writes, 1);
    check(we_lo == exp_w, "R6 strobe width", we_lo, exp_w);
    check(oe_cyc == exp_w + 2, "R6 setup/hold framing", oe_cyc, exp_w + 2);
    check(bad_oe == 0, "R2/R3 drive before halt or ack", bad_oe, 0);
    check(cap_addr == int'(a), "R4 address", cap_addr, a);
    check(cap_ce == 1, "R4 bank enable", cap_ce, 1);
    check(cap_data == int'(d), "R5 data", cap_data, d);
    check(err == 1'b0, "R9 no error", err, 0);
    check(halt_n && !bus_oe, "R10 released", {halt_n, bus_oe}, 2);
    ram_cmp("R8 other locations");
  endtask

  // {addr sw, data sw, width[3:0], ba delay[3:0]}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b1, 4'd1,  4'd0},
    {1'b1, 1'b1, 4'd3,  4'd2},
    {1'b1, 1'b0, 4'd0,  4'd5},
    {1'b0, 1'b0, 4'd15, 4'd1},
    {1'b1, 1'b1, 4'd2,  4'd9},
    {1'b0, 1'b1, 4'd4,  4'd0}
  };

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    if (!done) begin
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 256; a++) begin
        ram[b][a] = 4'((b * 7 + a) & 15);
        mirror[b][a] = 4'((b * 7 + a) & 15);
      end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(halt_n && !bus_oe && we_n && ce_n == 2'b11 && !err, "R1 reset state",
          {halt_n, bus_oe, we_n, ce_n, err}, 6'b101110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(halt_n && !bus_oe && we_n && ce_n == 2'b11, "R1 idle", {halt_n, bus_oe}, 2);

    for (int v = 0; v < 6; v++)
      run_op(VEC[v][9], VEC[v][8], int'(VEC[v][7:4]), int'(VEC[v][3:0]));

    // R9 timeout: bus_avail never rises
    ba_en = 0; clr_mon();
    @(negedge clk); req = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!halt_n, "R2 halt asserted", halt_n, 0);
    repeat (TMO + 10) @(negedge clk);
    check(err == 1'b1, "R9 timeout flag", err, 1);
    check(halt_n == 1'b1, "R9 halt released", halt_n, 1);
    check(oe_cyc == 0 && writes == 0, "R9 nothing driven", oe_cyc, 0);
    // R7 req still held: no new halt
    halt_lo_seen = 0;
    repeat (20) @(negedge clk);
    check(halt_lo_seen == 0, "R7 held req no restart", halt_lo_seen, 0);
    ram_cmp("R8 after timeout");
    req = 1'b0; ba_en = 1;
    repeat (2) @(negedge clk);

    // R9 error clears on next accepted request
    @(negedge clk); req = 1'b1;
    @(negedge clk); @(negedge clk);
    check(err == 1'b0, "R9 error cleared", err, 0);
    for (int i = 0; i < 200 && !halt_n; i++) @(negedge clk);
    clr_mon();
    repeat (30) @(negedge clk);
    check(writes == 0 && halt_lo_seen == 0, "R7 held req after write", writes, 0);
    req = 1'b0;
    mirror[1][sw_a] = {3'b000, sw_d};
    repeat (3) @(negedge clk);
    ram_cmp("R8 final");

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule